// File: doc/BRIEF.md
# PCI Inbound Memory Window Decoder

This block sits on the target side of a PCI bridge and decides whether an incoming memory transaction belongs to one of three inbound windows. Each window is described by a 32-bit base register. The register holds a 12-bit base address at 1 MB granularity, a size mask whose top three bits are fixed, and a prefetchable flag. The remaining fields are constant and read back at fixed values. Because the mask can be changed at run time, one register can describe a window from 1 MB up to 512 MB.

Software reaches the three registers through a small synchronous port. A select value picks a window, a write strobe loads the word on the next rising clock edge, and the read data follows the select combinationally. The decoder ANDs the upper twelve address bits with each window's mask and compares the result with that window's effective base, which is the base ANDed with the mask. If more than one window matches, the lowest-numbered window wins. The result is a valid flag, the window index and that window's prefetchable flag.

Top module: `pci_inwin_decode`

## Requirements
- R1: `reg_sel` values 0, 1 and 2 address window registers 0, 1 and 2, and the windows are independent. Select value 3 reads as 32'h0, and a write with select 3 changes no window.
- R2: Writable fields are: base in bits 31:20, low size mask (mask bits 28:20) in bits 12:4, and the prefetchable flag in bit 3. Each reads back the value last written.
- R3: Fixed fields read as follows and ignore writes: bits 19:16 read 4'b0000, bits 15:13 (mask bits 31:29) read 3'b111, bits 2:1 read 2'b00, bit 0 reads 0.
- R4: After reset, every window register reads 32'h0000_E008: base 0, low mask 0, prefetchable 1. Reset is synchronous and active high, and can be applied at any time.
- R5: The effective base is base AND mask, taken bit by bit over address bits 31:20. Base bits at positions where the mask is 0 have no effect on decode.
- R6: Window n matches when (addr[31:20] AND mask_n) equals the effective base of window n. Address bits 19:0 are never compared.
- R7: When several windows match, `hit_win` gives the lowest-numbered one and `hit_valid` is 1.
- R8: `hit_pref` equals the prefetchable flag of the winning window. When no window matches, `hit_valid`, `hit_win` and `hit_pref` are all 0.
- R9: Decode is combinational from `addr` and the register contents. A write changes decode and read data only after the next rising clock edge, so decode in the cycle of the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Window register select (3 = unused slot) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| addr | input | 32 | PCI memory address of the incoming access |
| hit_valid | output | 1 | Some window claims the address |
| hit_win | output | 2 | Index of the claiming window |
| hit_pref | output | 1 | Prefetchable flag of the claiming window |

## Verification
A register write and an address decode can happen in the same cycle, and they may touch the same window. The bench provokes this by driving a write to window 2 while the address sits in that window's new range. Decode is sampled before the clock edge and must still show the old mapping. It is sampled again after the edge and must show the new one. Priority overlap is also exercised: two windows are programmed so that their ranges intersect, and the lower index must win across the whole shared span.

// File: rtl/inwin_pkg.sv
package inwin_pkg;

    localparam int NUM_WIN    = 3;
    localparam int SEL_W      = 2;
    localparam int DATA_W     = 32;
    localparam int GRAN_LSB   = 20;
    localparam int CMP_W      = DATA_W - GRAN_LSB;
    localparam int MLO_W      = 9;
    localparam int MHI_W      = CMP_W - MLO_W;

    localparam int BASE_LSB   = 20;
    localparam int MLO_LSB    = 4;
    localparam int MHI_LSB    = MLO_LSB + MLO_W;
    localparam int PREF_BIT   = 3;

    localparam logic [MHI_W-1:0] MHI_FIXED = '1;
    localparam logic [CMP_W-1:0] BASE_RST  = '0;
    localparam logic [MLO_W-1:0] MLO_RST   = '0;
    localparam logic             PREF_RST  = 1'b1;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [MLO_W-1:0] mask_lo;
        logic             pref;
    } win_state_t;

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] win;
        logic             pref;
    } hit_t;

    function automatic logic [CMP_W-1:0] full_mask(input win_state_t s);
        return {MHI_FIXED, s.mask_lo};
    endfunction

    function automatic logic [CMP_W-1:0] eff_base(input win_state_t s);
        return s.base & full_mask(s);
    endfunction

    function automatic win_state_t unpack_word(input logic [DATA_W-1:0] w);
        win_state_t s;
        s.base    = w[BASE_LSB +: CMP_W];
        s.mask_lo = w[MLO_LSB +: MLO_W];
        s.pref    = w[PREF_BIT];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input win_state_t s);
        logic [DATA_W-1:0] w;
        w                       = '0;
        w[BASE_LSB +: CMP_W]    = s.base;
        w[MHI_LSB +: MHI_W]     = MHI_FIXED;
        w[MLO_LSB +: MLO_W]     = s.mask_lo;
        w[PREF_BIT]             = s.pref;
        return w;
    endfunction

endpackage

// File: rtl/inwin_reg.sv
module inwin_reg
    import inwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  win_state_t wr_val,
    output win_state_t state
);

    win_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.base    <= BASE_RST;
            state_q.mask_lo <= MLO_RST;
            state_q.pref    <= PREF_RST;
        end else if (wr_en) begin
            state_q <= wr_val;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/inwin_match.sv
module inwin_match
    import inwin_pkg::*;
(
    input  logic [CMP_W-1:0] addr_hi,
    input  win_state_t       state,
    output logic             match
);

    logic [CMP_W-1:0] mask;
    logic [CMP_W-1:0] ebase;

    always_comb begin
        mask  = full_mask(state);
        ebase = eff_base(state);
        match = ((addr_hi & mask) == ebase);
    end

endmodule

// File: rtl/inwin_prio.sv
module inwin_prio
    import inwin_pkg::*;
#(
    parameter int N = NUM_WIN
) (
    input  logic [N-1:0] match,
    input  logic [N-1:0] pref,
    output hit_t         hit
);

    always_comb begin
        hit = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit.valid = 1'b1;
                hit.win   = SEL_W'(i);
                hit.pref  = pref[i];
            end
        end
    end

endmodule

// File: rtl/pci_inwin_decode.sv
module pci_inwin_decode
    import inwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] addr,
    output logic              hit_valid,
    output logic [SEL_W-1:0]  hit_win,
    output logic              hit_pref
);

    win_state_t         win_st [NUM_WIN];
    logic [NUM_WIN-1:0] win_match;
    logic [NUM_WIN-1:0] win_pref;
    win_state_t         wr_val;
    hit_t               hit;
    logic               unused_bits;

    assign wr_val      = unpack_word(reg_wdata);
    assign unused_bits = ^{addr[GRAN_LSB-1:0]};

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        inwin_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (reg_wr && (reg_sel == SEL_W'(g))),
            .wr_val (wr_val),
            .state  (win_st[g])
        );

        inwin_match u_match (
            .addr_hi (addr[DATA_W-1:GRAN_LSB]),
            .state   (win_st[g]),
            .match   (win_match[g])
        );

        assign win_pref[g] = win_st[g].pref;
    end

    inwin_prio #(.N(NUM_WIN)) u_prio (
        .match (win_match),
        .pref  (win_pref),
        .hit   (hit)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_sel == SEL_W'(i)) begin
                reg_rdata = pack_word(win_st[i]);
            end
        end
    end

    assign hit_valid = hit.valid;
    assign hit_win   = hit.win;
    assign hit_pref  = hit.pref;

endmodule

// File: rtl/inwin_checker.sv
module inwin_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [2:0]  win_match,
    input logic        hit_valid,
    input logic [1:0]  hit_win,
    input logic        hit_pref
);

    // R3
    fixed_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel != 2'd3) |-> (reg_rdata[19:13] == 7'b0000111 && reg_rdata[2:0] == 3'b000));

    // R1
    spare_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3) |-> (reg_rdata == 32'h0));

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel != 2'd3) |=>
            ((reg_sel != $past(reg_sel)) ||
             (reg_rdata[31:20] == $past(reg_wdata[31:20]) &&
              reg_rdata[12:3] == $past(reg_wdata[12:3]))));

    // R4
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && reg_sel != 2'd3) |-> (reg_rdata == 32'h0000_E008));

    // R7
    low_wins_chk: assert property (@(posedge clk) disable iff (rst)
        win_match[0] |-> (hit_valid && hit_win == 2'd0));

    // R8
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (win_match == 3'b000) |-> (!hit_valid && hit_win == 2'd0 && !hit_pref));

    // R7
    any_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (win_match != 3'b000) |-> hit_valid);

endmodule

bind pci_inwin_decode inwin_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .win_match (win_match),
    .hit_valid (hit_valid),
    .hit_win   (hit_win),
    .hit_pref  (hit_pref)
);

// File: tb/test_pci_inwin_decode.sv
module test_pci_inwin_decode;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] addr = 32'h0;
    logic        hit_valid;
    logic [1:0]  hit_win;
    logic        hit_pref;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pci_inwin_decode i_pci_inwin_decode (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr(addr),
        .hit_valid(hit_valid), .hit_win(hit_win), .hit_pref(hit_pref)
    );

    // bench model of the three windows
    logic [11:0] m_base [3];
    logic [8:0]  m_mlo  [3];
    logic        m_pref [3];

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  go;

    function automatic void model_reset();
        for (int i = 0; i < 3; i++) begin
            m_base[i] = 12'h0; m_mlo[i] = 9'h0; m_pref[i] = 1'b1;
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] s);
        if (s == 2'd3) return 32'h0;
        return {m_base[s], 4'h0, 3'b111, m_mlo[s], m_pref[s], 3'b000};
    endfunction

    function automatic logic [31:0] model_hit(input logic [31:0] a);
        for (int i = 0; i < 3; i++) begin
            logic [11:0] m;
            m = {3'b111, m_mlo[i]};
            if ((a[31:20] & m) == (m_base[i] & m))
                return {28'h0, 1'b1, 2'(i), m_pref[i]};
        end
        return 32'h0;
    endfunction

    task automatic push(input bit rd, input logic [31:0] e, input string tag);
        item_t it;
        it.is_read = rd; it.exp = e; it.tag = tag;
        sb.push_back(it);
        -> go;
    endtask

    task automatic chk_hit(input logic [31:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        push(1'b0, model_hit(a), tag);
    endtask

    task automatic chk_read(input logic [1:0] s, input string tag);
        @(negedge clk);
        reg_sel = s;
        #1;
        push(1'b1, model_read(s), tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (s != 2'd3) begin
            m_base[s] = d[31:20]; m_mlo[s] = d[12:4]; m_pref[s] = d[3];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic logic [31:0] word(input logic [11:0] b, input logic [8:0] ml, input logic p);
        return {b, 4'h0, 3'b000, ml, p, 3'b000};
    endfunction

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(go);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_read ? reg_rdata : {28'h0, hit_valid, hit_win, hit_pref};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R4 reset values of every window
        for (int s = 0; s < 3; s++) chk_read(2'(s), "R4 reset readback");
        // R1 spare slot reads zero
        chk_read(2'd3, "R1 spare slot read");
        // R6 default 512 MB window, R7 window 0 wins, R8 pref 1
        chk_hit(32'h1ABC_DEF0, "R6 R7 default window");
        chk_hit(32'h2000_0000, "R8 default miss");

        // R3 fixed fields ignore writes, R2 writable fields land
        wr(2'd0, 32'hFFFF_FFFF);
        chk_read(2'd0, "R2 R3 all-ones write");
        wr(2'd0, 32'h0000_0000);
        chk_read(2'd0, "R2 R3 all-zeros write");

        // R1 independence of windows and ignored spare-slot write
        wr(2'd3, 32'hABC0_1FF0);
        for (int s = 0; s < 4; s++) chk_read(2'(s), "R1 spare write ignored");

        // overlapping map: w0 16 MB at 0x1000_0000, w1 256 MB at 0x1000_0000, w2 1 MB at 0x8000_0000
        wr(2'd0, word(12'h100, 9'h1F0, 1'b0));
        wr(2'd1, word(12'h100, 9'h100, 1'b1));
        wr(2'd2, word(12'h800, 9'h1FF, 1'b1));
        chk_hit(32'h1000_0000, "R7 overlap low wins");
        chk_hit(32'h10FF_FFFF, "R7 R8 overlap top edge");
        chk_hit(32'h1100_0000, "R8 window 1 pref");
        chk_hit(32'h1FFF_FFFF, "R6 window 1 top");
        chk_hit(32'h2000_0000, "R8 miss above w1");
        chk_hit(32'h8000_0000, "R6 window 2");
        chk_hit(32'h800F_FFFF, "R6 low bits ignored");
        chk_hit(32'h8010_0000, "R6 past 1 MB window");

        // R5 base bits under a zero mask have no effect
        wr(2'd1, word(12'h1FF, 9'h100, 1'b1));
        chk_hit(32'h1800_0000, "R5 masked base bits");
        chk_hit(32'h0100_0000, "R5 miss outside");
        chk_read(2'd1, "R2 base readback unmasked");

        // address sweep against model
        for (int k = 0; k < 16; k++) chk_hit({4'(k), 28'h0C0_0000}, "R6 sweep");

        // R9 write and decode in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = word(12'h400, 9'h1C0, 1'b0);
        addr = 32'h4200_0000;
        #1;
        push(1'b0, model_hit(32'h4200_0000), "R9 old map before edge");
        @(negedge clk);
        reg_wr = 1'b0;
        m_base[2] = 12'h400; m_mlo[2] = 9'h1C0; m_pref[2] = 1'b0;
        #1;
        push(1'b0, model_hit(32'h4200_0000), "R9 new map after edge");

        // R4 reset mid-run restores defaults
        do_reset();
        for (int s = 0; s < 3; s++) chk_read(2'(s), "R4 reset again");
        chk_hit(32'h4200_0000, "R4 decode after reset");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule